// File: doc/BRIEF.md
# Floppy Head Step Pulse Generator

This block moves a floppy drive head by a requested number of tracks. A single start strobe loads a track count, a direction and a data-rate code. The block then emits that many active-low step pulses with the required timing and raises a one-cycle done pulse when the move is finished. All step timing is measured in master-clock periods. The master clock runs at sixteen times the selected data rate. The block makes its own master-clock enable tick from the faster system clock, using a divider picked by the data-rate code.

The direction output is registered when a start is accepted and does not change until the next accepted start. High on the direction line means outward and low means inward. When the head moves outward, the block reads the active-low track-0 input before each pulse would begin. If the head already sits over the outermost track, no further pulse is issued, an at-track-0 flag is set and done is signalled early. A start that arrives while a move is in progress is dropped. A zero track count finishes at once.

Top module: `head_step_gen`

## Requirements
- R1: After reset, step_n is 1, head_dir_n is 1, busy is 0, done is 0 and at_trk0 is 0.
- R2: On an accepted start, head_dir_n takes the value of outward (1 = outward, 0 = inward) and stays constant for as long as busy is 1.
- R3: The first step pulse falls exactly T_SETUP (4) master-clock periods after the clock edge that accepts the start.
- R4: Every step pulse holds step_n low for exactly T_LOW (24) master-clock periods.
- R5: Falling edges of successive step pulses are exactly T_CYCLE (132) master-clock periods apart.
- R6: After the last pulse rises, direction is held for T_HOLD (96) master-clock periods. busy then drops and done is 1 for exactly one cycle, on the same edge.
- R7: A move with a nonzero count and no track-0 stop produces exactly step_count pulses, and step_n stays high whenever busy is 0.
- R8: One master-clock period lasts DIV_1M*1000/kbps system cycles. The rate_sel codes map to kbps as 0 = 1000, 1 = 500, 2 = 300 and 3 = 250. The code is latched at the accepted start.
- R9: A start with step_count 0 while idle gives done 1 in the cycle after the accepting edge, with no pulse and busy staying 0.
- R10: A start while busy is ignored: pulse count, direction and timing of the current move are unchanged.
- R11: On an outward move, trk0_n low at a pulse boundary stops the move. No further pulse is issued, at_trk0 becomes 1 together with done, and at_trk0 is cleared by the next accepted start. On an inward move, trk0_n is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Start strobe, accepted only when idle |
| step_count | input | CNT_W | Number of tracks to move |
| outward | input | 1 | 1 moves the head outward, 0 moves it inward |
| rate_sel | input | 2 | Data-rate code selecting the master-clock period |
| trk0_n | input | 1 | Track-0 sense from the drive, active low, asynchronous |
| head_dir_n | output | 1 | Direction line: high is outward, low is inward |
| step_n | output | 1 | Step line, active-low pulse per track |
| busy | output | 1 | A move is in progress |
| done | output | 1 | One-cycle pulse at the end of a move |
| at_trk0 | output | 1 | The last move was stopped by track 0 |

## Verification
Moves of one to five tracks are run in both directions at all four rate codes. This separates a divider or phase-length error, which shifts every measured interval by a rate-dependent amount, from a count error, which shows up only in the number of pulses. A modelled head position drives trk0_n. An inward move that passes over track 0 must ignore it. An outward move that lands exactly on track 0 must finish normally without the flag. An outward move that overshoots must stop early with the flag set. A start injected during a move and a zero-count start check the two cases where a start must leave no trace.

// File: rtl/hsg_pkg.sv
package hsg_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SETUP,
    ST_LOW,
    ST_GAP,
    ST_HOLD
  } hsg_state_e;

  // data rate in kbit/s for each rate code
  function automatic int rate_kbps(input logic [1:0] code);
    case (code)
      2'd0:    return 1000;
      2'd1:    return 500;
      2'd2:    return 300;
      default: return 250;
    endcase
  endfunction

  // system cycles per master-clock period
  function automatic int mclk_div(input logic [1:0] code, input int div_1m);
    return (div_1m * 1000) / rate_kbps(code);
  endfunction

endpackage

// File: rtl/hsg_mclk_div.sv
module hsg_mclk_div
  import hsg_pkg::*;
#(
  parameter int DIV_1M = 3
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       clr,
  input  logic [1:0] rate,
  output logic       tick
);
  localparam int MAX_DIV = DIV_1M * 4;
  localparam int W       = $clog2(MAX_DIV + 1);

  logic [W-1:0] cnt;
  logic [W-1:0] last;

  always_comb last = W'(mclk_div(rate, DIV_1M) - 1);

  assign tick = (cnt == last);

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      cnt <= '0;
    end else if (tick) begin
      cnt <= '0;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/hsg_sync2.sv
module hsg_sync2 #(
  parameter logic RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic dout
);
  logic meta;

  always_ff @(posedge clk) begin
    if (rst) begin
      meta <= RST_VAL;
      dout <= RST_VAL;
    end else begin
      meta <= din;
      dout <= meta;
    end
  end
endmodule

// File: rtl/hsg_phase_timer.sv
module hsg_phase_timer #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  input  logic         tick,
  input  logic [W-1:0] len,
  output logic         phase_end
);
  logic [W-1:0] cnt;

  assign phase_end = tick && (cnt == len - 1'b1);

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      cnt <= '0;
    end else if (phase_end) begin
      cnt <= '0;
    end else if (tick) begin
      cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/head_step_gen.sv
module head_step_gen
  import hsg_pkg::*;
#(
  parameter int DIV_1M  = 3,
  parameter int CNT_W   = 8,
  parameter int T_SETUP = 4,
  parameter int T_LOW   = 24,
  parameter int T_CYCLE = 132,
  parameter int T_HOLD  = 96
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [CNT_W-1:0] step_count,
  input  logic             outward,
  input  logic [1:0]       rate_sel,
  input  logic             trk0_n,
  output logic             head_dir_n,
  output logic             step_n,
  output logic             busy,
  output logic             done,
  output logic             at_trk0
);
  localparam int T_GAP = T_CYCLE - T_LOW;
  localparam int TW    = $clog2(T_CYCLE + 1);

  hsg_state_e       state;
  logic [CNT_W-1:0] left_q;
  logic             dir_q;
  logic [1:0]       rate_q;
  logic             step_q;
  logic             done_q;
  logic             flag_q;
  logic [TW-1:0]    phase_len;

  // named internal events
  logic mclk_tick;
  logic phase_end;
  logic accept;
  logic trk0_s_n;
  logic trk0_hit;

  assign accept   = start && (state == ST_IDLE);
  assign trk0_hit = dir_q && !trk0_s_n;

  hsg_mclk_div #(.DIV_1M(DIV_1M)) i_div (
    .clk (clk),
    .rst (rst),
    .clr (accept),
    .rate(rate_q),
    .tick(mclk_tick)
  );

  hsg_sync2 #(.RST_VAL(1'b1)) i_trk0_sync (
    .clk (clk),
    .rst (rst),
    .din (trk0_n),
    .dout(trk0_s_n)
  );

  always_comb begin
    case (state)
      ST_SETUP: phase_len = TW'(T_SETUP);
      ST_LOW:   phase_len = TW'(T_LOW);
      ST_GAP:   phase_len = TW'(T_GAP);
      ST_HOLD:  phase_len = TW'(T_HOLD);
      default:  phase_len = TW'(T_SETUP);
    endcase
  end

  hsg_phase_timer #(.W(TW)) i_timer (
    .clk      (clk),
    .rst      (rst),
    .clr      (accept),
    .tick     (mclk_tick),
    .len      (phase_len),
    .phase_end(phase_end)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state  <= ST_IDLE;
      left_q <= '0;
      dir_q  <= 1'b1;
      rate_q <= '0;
      step_q <= 1'b1;
      done_q <= 1'b0;
      flag_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (accept) begin
        flag_q <= 1'b0;
        dir_q  <= outward;
        rate_q <= rate_sel;
        left_q <= step_count;
        if (step_count == '0) begin
          done_q <= 1'b1;
        end else begin
          state <= ST_SETUP;
        end
      end else if (phase_end) begin
        case (state)
          ST_SETUP, ST_GAP: begin
            if (trk0_hit) begin
              state  <= ST_IDLE;
              done_q <= 1'b1;
              flag_q <= 1'b1;
            end else begin
              state  <= ST_LOW;
              step_q <= 1'b0;
            end
          end
          ST_LOW: begin
            step_q <= 1'b1;
            left_q <= left_q - 1'b1;
            state  <= (left_q == CNT_W'(1)) ? ST_HOLD : ST_GAP;
          end
          ST_HOLD: begin
            state  <= ST_IDLE;
            done_q <= 1'b1;
          end
          default: state <= ST_IDLE;
        endcase
      end
    end
  end

  assign head_dir_n = dir_q;
  assign step_n     = step_q;
  assign busy       = (state != ST_IDLE);
  assign done       = done_q;
  assign at_trk0    = flag_q;
endmodule

// File: rtl/hsg_chk.sv
module hsg_chk #(
  parameter int CNT_W = 8,
  parameter int T_LOW = 24
) (
  input logic             clk,
  input logic             rst,
  input logic             start,
  input logic [CNT_W-1:0] step_count,
  input logic             head_dir_n,
  input logic             step_n,
  input logic             busy,
  input logic             done,
  input logic             at_trk0,
  input logic             mclk_tick
);
  localparam int LW = $clog2(T_LOW + 2);

  logic [LW-1:0] low_ticks;

  always_ff @(posedge clk) begin
    if (rst || step_n) begin
      low_ticks <= '0;
    end else if (mclk_tick) begin
      low_ticks <= low_ticks + 1'b1;
    end
  end

  p_dir_stable_r2: assert property (@(posedge clk) disable iff (rst)
    (busy && $past(busy)) |-> (head_dir_n == $past(head_dir_n)));

  p_low_width_r4: assert property (@(posedge clk) disable iff (rst)
    $rose(step_n) |-> (low_ticks == LW'(T_LOW)));

  p_done_ends_busy_r6: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> done);

  p_done_idle_r6: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);

  p_idle_step_high_r7: assert property (@(posedge clk) disable iff (rst)
    !busy |-> step_n);

  p_zero_count_r9: assert property (@(posedge clk) disable iff (rst)
    (start && !busy && step_count == '0) |=> (done && !busy));

  p_busy_start_ignored_r10: assert property (@(posedge clk) disable iff (rst)
    (busy && start) |=> $stable(head_dir_n));

  p_trk0_flag_r11: assert property (@(posedge clk) disable iff (rst)
    $rose(at_trk0) |-> (done && !busy));
endmodule

bind head_step_gen hsg_chk #(.CNT_W(CNT_W), .T_LOW(T_LOW)) i_hsg_chk (
  .clk       (clk),
  .rst       (rst),
  .start     (start),
  .step_count(step_count),
  .head_dir_n(head_dir_n),
  .step_n    (step_n),
  .busy      (busy),
  .done      (done),
  .at_trk0   (at_trk0),
  .mclk_tick (mclk_tick)
);

// File: tb/test_head_step_gen.sv
module test_head_step_gen;
  localparam int DIV_1M = 3;

  logic       clk = 1'b0;
  logic       rst;
  logic       start;
  logic [7:0] step_count;
  logic       outward;
  logic [1:0] rate_sel;
  logic       trk0_n;
  logic       head_dir_n, step_n, busy, done, at_trk0;

  int checks = 0;
  int fails  = 0;

  always #10 clk = ~clk;

  head_step_gen #(.DIV_1M(DIV_1M), .CNT_W(8)) i_head_step_gen (
    .clk(clk), .rst(rst), .start(start), .step_count(step_count),
    .outward(outward), .rate_sel(rate_sel), .trk0_n(trk0_n),
    .head_dir_n(head_dir_n), .step_n(step_n), .busy(busy),
    .done(done), .at_trk0(at_trk0)
  );

  // fields: count[27:20] outward[19] rate[18:17] start_pos[16:9] pulses[8:1] flag[0]
  localparam logic [27:0] VEC [7] = '{
    {8'd3, 1'b0, 2'd0, 8'd5,  8'd3, 1'b0},
    {8'd2, 1'b1, 2'd1, 8'd10, 8'd2, 1'b0},
    {8'd2, 1'b0, 2'd2, 8'd0,  8'd2, 1'b0},
    {8'd1, 1'b1, 2'd3, 8'd4,  8'd1, 1'b0},
    {8'd5, 1'b1, 2'd0, 8'd2,  8'd2, 1'b1},
    {8'd3, 1'b1, 2'd1, 8'd0,  8'd0, 1'b1},
    {8'd2, 1'b1, 2'd0, 8'd2,  8'd2, 1'b0}
  };

  task automatic chk(input bit ok, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", what, act, exp);
    end
  endtask

  // sys cycles per master-clock period: DIV_1M scaled by 1 Mbps over the rate
  function automatic int per_mclk(input int code);
    int kb;
    kb = (code == 0) ? 1000 : (code == 1) ? 500 : (code == 2) ? 300 : 250;
    return DIV_1M * 1000 / kb;
  endfunction

  task automatic run_vec(input logic [27:0] v, input bit inject);
    int  cnt_v, rate_v, pos, exp_p, d, t, pulses, last_fall, last_rise;
    bit  out_v, flag_v, prev;
    cnt_v  = int'(v[27:20]);
    out_v  = v[19];
    rate_v = int'(v[18:17]);
    pos    = int'(v[16:9]);
    exp_p  = int'(v[8:1]);
    flag_v = v[0];
    d      = per_mclk(rate_v);
    trk0_n     = (pos == 0) ? 1'b0 : 1'b1;
    step_count = 8'(cnt_v);
    outward    = out_v;
    rate_sel   = 2'(rate_v);
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    chk(at_trk0 == 1'b0, "R11 flag cleared by start", int'(at_trk0), 0);
    chk(busy == 1'b1, "R7 busy after start", int'(busy), 1);
    chk(head_dir_n == out_v, "R2 direction latched", int'(head_dir_n), int'(out_v));
    t = 0; pulses = 0; prev = 1'b1; last_fall = 0; last_rise = 0;
    while (!done && t < 20000) begin
      @(negedge clk);
      t++;
      if (inject && start) begin
        start = 1'b0; outward = out_v; step_count = 8'(cnt_v);
      end
      if (prev && !step_n) begin
        if (pulses == 0) chk(t == 4 * d, "R3 R8 setup to first step", t, 4 * d);
        else chk(t - last_fall == 132 * d, "R5 R8 step period", t - last_fall, 132 * d);
        chk(head_dir_n == out_v, "R2 direction at step", int'(head_dir_n), int'(out_v));
        pulses++;
        last_fall = t;
        if (out_v) begin
          if (pos > 0) pos--;
        end else pos++;
        trk0_n = (pos == 0) ? 1'b0 : 1'b1;
        if (inject && pulses == 1) begin
          start = 1'b1; step_count = 8'd1; outward = !out_v;
        end
      end
      if (!prev && step_n) begin
        chk(t - last_fall == 24 * d, "R4 R8 step width", t - last_fall, 24 * d);
        last_rise = t;
      end
      prev = step_n;
    end
    chk(done == 1'b1, "R6 done reached", int'(done), 1);
    if (!flag_v && cnt_v > 0)
      chk(t - last_rise == 96 * d, "R6 direction hold", t - last_rise, 96 * d);
    chk(busy == 1'b0, "R6 busy low at done", int'(busy), 0);
    chk(pulses == exp_p, "R7 R11 pulse count", pulses, exp_p);
    if (inject) chk(pulses == exp_p, "R10 start during move ignored", pulses, exp_p);
    chk(at_trk0 == flag_v, "R11 track-0 flag", int'(at_trk0), int'(flag_v));
    @(negedge clk);
    chk(done == 1'b0, "R6 done single cycle", int'(done), 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=hung expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    rst = 1'b1; start = 1'b0; step_count = '0; outward = 1'b0;
    rate_sel = '0; trk0_n = 1'b1;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk(step_n == 1'b1, "R1 step idle", int'(step_n), 1);
    chk(head_dir_n == 1'b1, "R1 direction idle", int'(head_dir_n), 1);
    chk(busy == 1'b0, "R1 busy idle", int'(busy), 0);
    chk(done == 1'b0, "R1 done idle", int'(done), 0);
    chk(at_trk0 == 1'b0, "R1 flag idle", int'(at_trk0), 0);

    for (int i = 0; i < 7; i++) run_vec(VEC[i], 1'b0);

    // R10: start injected during a 3-track inward move
    run_vec({8'd3, 1'b0, 2'd0, 8'd5, 8'd3, 1'b0}, 1'b1);

    // R9: zero count
    step_count = 8'd0; outward = 1'b1; trk0_n = 1'b1;
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    chk(done == 1'b1, "R9 zero count done", int'(done), 1);
    chk(busy == 1'b0, "R9 zero count not busy", int'(busy), 0);
    chk(step_n == 1'b1, "R9 zero count no step", int'(step_n), 1);
    @(negedge clk);
    chk(done == 1'b0, "R9 done single cycle", int'(done), 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule